// File: doc/BRIEF.md
# Filtered Gated Event-Count Front End

This block sits between two external pins and a down-counter. The event pin is synchronized and then optionally cleaned by a digital noise filter. The filter can run on every clock, on every 8th clock or on every 32nd clock. The cleaned level feeds an edge detector that turns the rising edges, the falling edges or both into one-cycle count strobes.

The second pin, the enable input, is also synchronized. It gates those strobes in one of five ways: it is ignored, counting follows its low level, counting follows its high level, counting starts on a chosen edge, or a chosen edge restarts counting. In restart mode the block also raises a one-cycle reload request so that the counter reloads its start value. The gating applies only while a global external-trigger enable is set. Changing the configuration clears the started state and the filter history, so every new setting begins from a known point.

Top module: `evt_gate_frontend`

## Requirements
- R1: With the filter bypassed (`filt_sel`=0), a level change on `evt_in` made between clock edges produces its strobe in the cycle after the third following rising clock edge, and the strobe lasts one cycle. Two flops synchronize the input and one flop holds the filtered level.
- R2: With the filter on, the filtered level follows the input only once three consecutive samples agree. A pulse that spans at most two samples produces no strobe. A pulse that spans four or more samples produces the strobes of its edges.
- R3: The `filt_sel` encoding sets the sample rate: 0 bypasses the filter, 1 samples every clock, 2 samples every 8th clock and 3 samples every 32nd clock.
- R4: The `evt_edge` encoding selects which edges of the filtered event are counted: 0 counts rising edges, 1 counts falling edges, and 2 or 3 counts both. Each selected edge gives exactly one strobe.
- R5: The `gate_mode` encoding is 0 ignored, 1 active-low, 2 active-high, 3 start and 4 restart. Codes 5 to 7 act as ignored. In ignored mode, and in every mode while `ext_trig_en` is 0, every strobe is passed and `reload_req` stays low.
- R6: In mode 1, strobes pass only while the synchronized enable is low. In mode 2, they pass only while it is high.
- R7: In mode 3 no strobe passes until the selected trigger edge appears on the enable input. After that edge, strobes pass. The `trig_edge` encoding is 0 rising, 1 falling, and 2 or 3 both.
- R8: In mode 4, each selected trigger edge raises `reload_req` for exactly one cycle, and no strobe is issued in that cycle. Strobes pass from the first trigger edge onward.
- R9: Any change of `filt_sel`, `evt_edge`, `gate_mode` or `trig_edge`, and any cycle in which `ext_trig_en` is 0, clears the started state. A new trigger edge is then needed before mode 3 or mode 4 passes strobes again.
- R10: `count_strobe` and `reload_req` are never high in the same cycle, and both are low during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 1 | Raw external event input |
| en_in | input | 1 | Raw external enable input |
| filt_sel | input | 2 | Filter sample-rate select |
| evt_edge | input | 2 | Event edge select |
| gate_mode | input | 3 | Enable gating mode |
| trig_edge | input | 2 | Trigger edge for start and restart modes |
| ext_trig_en | input | 1 | Global enable for the enable-input gating |
| count_strobe | output | 1 | Gated one-cycle count strobe |
| reload_req | output | 1 | One-cycle counter reload request |

## Verification
The assertions check four properties on every cycle:
- the two outputs are mutually exclusive;
- a reload request appears only in restart mode with gating enabled;
- the level modes block strobes against the synchronized enable;
- in rising-edge mode no strobe follows another in the next cycle.

The filter acceptance windows at each sample rate, the edge counts per pulse, the exact three-cycle bypass latency, and the start and restart sequences (including the clearing of the started state on a configuration change) span many cycles and arbitrary input histories. Only the bench's sweeps show those, by comparing strobe and reload totals against counts worked out from the pulse patterns.

// File: rtl/evt_gate_frontend.sv
module evt_gate_frontend #(
  parameter int DIV_MID  = 8,
  parameter int DIV_SLOW = 32,
  parameter int FILT_LEN = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_in,
  input  logic       en_in,
  input  logic [1:0] filt_sel,
  input  logic [1:0] evt_edge,
  input  logic [2:0] gate_mode,
  input  logic [1:0] trig_edge,
  input  logic       ext_trig_en,
  output logic       count_strobe,
  output logic       reload_req
);
  localparam int PW = (DIV_SLOW > 1) ? $clog2(DIV_SLOW) : 1;
  localparam int HW = FILT_LEN - 1;
  localparam int CW = 9;
  localparam logic [2:0] M_LOW = 3'd1, M_HIGH = 3'd2, M_START = 3'd3, M_RESTART = 3'd4;

  logic          evt_s1, evt_s2, en_s1, en_s2, en_d;
  logic [PW-1:0] pre;
  logic          tick_mid, tick_slow, tick;
  logic [HW-1:0] hist;
  logic [HW:0]   win;
  logic          filt, filt_d;
  logic [CW-1:0] cfg_now, cfg_q;
  logic          cfg_chg;
  logic          evt_rise, evt_fall, raw_evt;
  logic          en_rise, en_fall, trig_hit;
  logic          started, gate_open;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {evt_s1, evt_s2, en_s1, en_s2, en_d} <= '0;
    else begin
      evt_s1 <= evt_in;
      evt_s2 <= evt_s1;
      en_s1  <= en_in;
      en_s2  <= en_s1;
      en_d   <= en_s2;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre <= '0;
    else if (int'(pre) == DIV_SLOW - 1) pre <= '0;
    else pre <= pre + 1'b1;

  assign tick_mid  = (int'(pre) % DIV_MID) == DIV_MID - 1;
  assign tick_slow = int'(pre) == DIV_SLOW - 1;

  always_comb
    case (filt_sel)
      2'd2:    tick = tick_mid;
      2'd3:    tick = tick_slow;
      default: tick = 1'b1;
    endcase

  assign cfg_now = {filt_sel, evt_edge, gate_mode, trig_edge};
  assign cfg_chg = cfg_now != cfg_q;
  assign win     = {hist, evt_s2};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cfg_q <= '0;
    else cfg_q <= cfg_now;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hist <= '0;
    else if (cfg_chg) hist <= {HW{filt}};
    else if (tick) hist <= win[HW-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      filt   <= 1'b0;
      filt_d <= 1'b0;
    end else begin
      filt_d <= filt;
      if (filt_sel == 2'd0) filt <= evt_s2;
      else if (tick && !cfg_chg && (&win || ~|win)) filt <= evt_s2;
    end

  assign evt_rise = filt & ~filt_d;
  assign evt_fall = ~filt & filt_d;
  assign raw_evt  = (evt_edge == 2'd0) ? evt_rise :
                    (evt_edge == 2'd1) ? evt_fall : (evt_rise | evt_fall);

  assign en_rise  = en_s2 & ~en_d;
  assign en_fall  = ~en_s2 & en_d;
  assign trig_hit = (trig_edge == 2'd0) ? en_rise :
                    (trig_edge == 2'd1) ? en_fall : (en_rise | en_fall);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) started <= 1'b0;
    else if (cfg_chg || !ext_trig_en) started <= 1'b0;
    else if ((gate_mode == M_START || gate_mode == M_RESTART) && trig_hit) started <= 1'b1;

  always_comb
    if (!ext_trig_en) gate_open = 1'b1;
    else
      case (gate_mode)
        M_LOW:              gate_open = ~en_s2;
        M_HIGH:             gate_open = en_s2;
        M_START, M_RESTART: gate_open = started;
        default:            gate_open = 1'b1;
      endcase

  assign reload_req   = ext_trig_en && gate_mode == M_RESTART && trig_hit && !cfg_chg;
  assign count_strobe = raw_evt && gate_open && !reload_req;
endmodule

module evt_gate_frontend_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       count_strobe,
  input logic       reload_req,
  input logic       ext_trig_en,
  input logic [2:0] gate_mode,
  input logic [1:0] evt_edge,
  input logic       en_sync
);
  assert_outputs_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(count_strobe && reload_req));

  assert_reload_only_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reload_req |-> (ext_trig_en && gate_mode == 3'd4));

  assert_high_mode_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_trig_en && gate_mode == 3'd2 && !en_sync) |-> !count_strobe);

  assert_low_mode_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_trig_en && gate_mode == 3'd1 && en_sync) |-> !count_strobe);

  assert_rise_no_repeat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (count_strobe && evt_edge == 2'd0) |=> (!count_strobe || evt_edge != 2'd0));
endmodule

bind evt_gate_frontend evt_gate_frontend_chk u_chk (
  .clk(clk), .rst_n(rst_n), .count_strobe(count_strobe), .reload_req(reload_req),
  .ext_trig_en(ext_trig_en), .gate_mode(gate_mode), .evt_edge(evt_edge), .en_sync(en_s2)
);

// File: tb/evt_gate_frontend_test.sv
`timescale 1ns/1ps
module evt_gate_frontend_test;
  logic clk = 0, rst_n = 0, evt_in = 0, en_in = 0, ext_trig_en = 0;
  logic [1:0] filt_sel = 0, evt_edge = 0, trig_edge = 0;
  logic [2:0] gate_mode = 0;
  logic count_strobe, reload_req;
  int n_chk = 0, n_bad = 0, sc = 0, rc = 0, wide = 0;
  logic prev_rl = 0;
  bit done = 0;

  always #5 clk = ~clk;

  evt_gate_frontend uut (.*);

  always @(negedge clk) if (rst_n) begin
    if (count_strobe) sc++;
    if (reload_req) rc++;
    if (reload_req && prev_rl) wide++;
    prev_rl = reload_req;
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int hi, int lo);
    evt_in = 1; wait_cyc(hi);
    evt_in = 0; wait_cyc(lo);
  endtask

  task automatic burst(int k);
    for (int i = 0; i < k; i++) pulse(2, 2);
    wait_cyc(6);
  endtask

  task automatic set_en(logic v);
    en_in = v; wait_cyc(5);
  endtask

  int base, rbase;

  initial begin
    wait_cyc(3);
    check("R10 reset strobe", int'(count_strobe), 0);
    check("R10 reset reload", int'(reload_req), 0);
    rst_n = 1;
    wait_cyc(4);

    // R1: exact bypass latency
    evt_in = 1;
    wait_cyc(2); check("R1 strobe not yet", int'(count_strobe), 0);
    wait_cyc(1); check("R1 strobe at third edge", int'(count_strobe), 1);
    wait_cyc(1); check("R1 strobe one cycle", int'(count_strobe), 0);
    evt_in = 0; wait_cyc(8);

    // R2 R3 R4: sweep of filter rate and edge select
    for (int fs = 0; fs < 4; fs++)
      for (int ee = 0; ee < 4; ee++) begin
        int d, l, per, exp_n;
        d = (fs == 2) ? 8 : (fs == 3) ? 32 : 1;
        l = 4 * d + 4;
        per = (ee < 2) ? 1 : 2;
        filt_sel = 2'(fs); evt_edge = 2'(ee);
        wait_cyc(2 * l);
        base = sc;
        for (int p = 0; p < 3; p++) pulse(l, l);
        for (int g = 0; g < 3; g++) pulse(2 * d, l);
        wait_cyc(l);
        exp_n = 3 * per + ((fs == 0) ? 3 * per : 0);
        check($sformatf("R2 R3 R4 fs=%0d edge=%0d", fs, ee), sc - base, exp_n);
      end

    filt_sel = 0; evt_edge = 0; wait_cyc(4);

    // R5: ignored mode, gating off, codes 5..7
    ext_trig_en = 1; gate_mode = 0; set_en(0);
    base = sc; burst(4); check("R5 ignored mode", sc - base, 4);
    gate_mode = 3'd6; wait_cyc(2);
    base = sc; burst(3); check("R5 code 6 acts as ignored", sc - base, 3);
    ext_trig_en = 0; gate_mode = 3'd2; wait_cyc(2);
    base = sc; burst(5); check("R5 gating off in high mode", sc - base, 5);

    // R6: level modes
    ext_trig_en = 1; gate_mode = 3'd2; set_en(1);
    base = sc; burst(4); check("R6 high mode en=1", sc - base, 4);
    set_en(0);
    base = sc; burst(4); check("R6 high mode en=0", sc - base, 0);
    gate_mode = 3'd1; wait_cyc(2);
    base = sc; burst(3); check("R6 low mode en=0", sc - base, 3);
    set_en(1);
    base = sc; burst(3); check("R6 low mode en=1", sc - base, 0);

    // R7: start on falling edge
    gate_mode = 3'd3; trig_edge = 2'd1; wait_cyc(3);
    base = sc; burst(3); check("R7 start before trigger", sc - base, 0);
    set_en(0);
    base = sc; burst(3); check("R7 start after falling edge", sc - base, 3);
    set_en(1);
    base = sc; burst(2); check("R7 stays started", sc - base, 2);

    // R9: config change clears started
    trig_edge = 2'd0; wait_cyc(3);
    base = sc; burst(3); check("R9 cleared by config change", sc - base, 0);
    set_en(0); set_en(1);
    base = sc; burst(2); check("R7 start after rising edge", sc - base, 2);
    ext_trig_en = 0; wait_cyc(2); ext_trig_en = 1; wait_cyc(2);
    base = sc; burst(2); check("R9 cleared by gating off", sc - base, 0);

    // R8: restart mode
    gate_mode = 3'd4; trig_edge = 2'd0; set_en(0);
    rbase = rc;
    base = sc; burst(3); check("R8 restart before trigger", sc - base, 0);
    set_en(1);
    check("R8 one reload on rising edge", rc - rbase, 1);
    base = sc; burst(3); check("R8 counts after restart", sc - base, 3);
    rbase = rc; set_en(0);
    check("R8 no reload on falling edge", rc - rbase, 0);
    trig_edge = 2'd2; wait_cyc(3);
    rbase = rc; set_en(1); set_en(0);
    check("R8 both edges two reloads", rc - rbase, 2);
    base = sc; burst(2); check("R8 counts in both-edge restart", sc - base, 2);
    check("R8 reload width one cycle", wide, 0);

    ext_trig_en = 0; rbase = rc; set_en(1); set_en(0);
    check("R5 no reload with gating off", rc - rbase, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2ms;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule